// File: doc/BRIEF.md
# Per-word speculative access tracker

This block holds the speculative bookkeeping for one cache line version owned by a single epoch. It stores a valid flag, the owning epoch tag and two flags per word. One flag records that the owner has written the word. The other records that the owner read the word before writing it. Local accesses from the owning epoch update these flags. A local access from any other epoch, or to an empty slot, replaces the slot with a fresh copy tagged with the new epoch.

For each local read, the block reports in the same cycle whether the word must be fetched from outside (exposed) or can be served by this version. Incoming write snoops arrive with a two-bit order relation between the writer's epoch and this line's epoch. The block raises a dependence violation when the writer precedes this line's epoch and the snooped word was read exposed. Because the flags are kept per word, writes to neighbouring words never cause a violation. An invalidate-by-epoch port drops the version when its epoch is squashed.

The coherence protocol, the data storage and the computation of the epoch order lie outside this block.

Top module: `spec_word_tracker`

## Requirements
- R1: A local write by the owning epoch sets the write flag of the addressed word only. Other words keep their flags.
- R2: A local read by the owning epoch of a word with both flags clear is reported exposed (`rd_exposed`=1 in the same cycle). It sets that word's exposed-read flag.
- R3: A local read by the owning epoch of a word whose write flag or exposed-read flag is set is not exposed. It leaves the exposed-read flag unchanged, so a read after a write never marks the word exposed.
- R4: A local read while the slot is invalid, or while it is tagged with a different epoch, is reported exposed.
- R5: A snoop with `snp_rel`=2'b01 (the writer's epoch precedes the line's epoch) to a word whose exposed-read flag is set raises `dep_viol` in the same cycle. A snoop to a word with only its write flag set, or with no flag set, does not raise it.
- R6: No violation is raised for `snp_rel` 2'b00 (same epoch), 2'b10 (writer is a successor) or 2'b11 (unordered), nor while the slot is invalid.
- R7: An invalidate whose epoch equals the slot's tag clears the valid flag and all word flags at the next edge. An invalidate carrying any other epoch is ignored.
- R8: A local access from an epoch other than the tag, or to an invalid slot, allocates the slot at the next edge. The new copy takes the accessing epoch as its tag and starts with all word flags clear, except that the accessed word gets its write flag (write) or its exposed-read flag (read).
- R9: After reset the slot is invalid, and neither `rd_exposed` nor `dep_viol` is asserted while no access or snoop is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Local access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | $clog2(WORDS) | Word index within the line |
| acc_epoch | input | EPOCH_W | Epoch issuing the local access |
| inv_valid | input | 1 | Squash-invalidate strobe |
| inv_epoch | input | EPOCH_W | Epoch being squashed |
| snp_valid | input | 1 | Incoming write snoop strobe |
| snp_word | input | $clog2(WORDS) | Word written by the remote epoch |
| snp_rel | input | 2 | Order of the writer relative to the line epoch: 00 same, 01 writer precedes, 10 writer follows, 11 unordered |
| rd_exposed | output | 1 | Current local read needs a fill |
| dep_viol | output | 1 | Current snoop is a dependence violation |
| line_valid | output | 1 | Slot holds a live version |
| line_epoch | output | EPOCH_W | Epoch tag of the held version |

## Verification
Several corner cases are targeted. A read following a write to the same word must stay local and must not create exposed-read state. A design that set the exposed flag on every read would then report false violations on snoops. Snoops to a written-but-unread word, and to a neighbouring word, must stay silent; a per-line tracker would flag both. An access from a foreign epoch must start from clean flags, which is seen as a fresh exposed read on a word the old owner had written. A squash must hit only the matching epoch, since a tag compare that was dropped would wipe unrelated versions.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;

  typedef enum logic [1:0] {
    REL_SAME    = 2'b00,
    REL_WR_PRED = 2'b01,
    REL_WR_SUCC = 2'b10,
    REL_UNORD   = 2'b11
  } ord_rel_e;

  // a word must be fetched when neither flag covers it
  function automatic logic word_needs_fill(input logic wr_f, input logic xr_f);
    return !(wr_f || xr_f);
  endfunction

  // exposed flag is gained only by a read of a word not yet written
  function automatic logic xr_next(input logic xr_f, input logic wr_f,
                                   input logic sel, input logic is_rd);
    return xr_f || (sel && is_rd && !wr_f);
  endfunction

  // an older writer clobbering a word this version consumed early
  function automatic logic is_violation(input ord_rel_e rel, input logic xr_f);
    return (rel == REL_WR_PRED) && xr_f;
  endfunction

endpackage

// File: rtl/spec_line_tag.sv
module spec_line_tag #(
  parameter int EPOCH_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [EPOCH_W-1:0] acc_epoch,
  input  logic               inv_valid,
  input  logic [EPOCH_W-1:0] inv_epoch,
  output logic               valid_q,
  output logic [EPOCH_W-1:0] tag_q,
  output logic               tag_hit,
  output logic               inv_hit,
  output logic               acc_go,
  output logic               clr_bits
);
  logic alloc;

  assign tag_hit  = valid_q && (tag_q == acc_epoch);
  assign inv_hit  = inv_valid && valid_q && (tag_q == inv_epoch);
  assign acc_go   = acc_valid && !inv_hit;
  assign alloc    = acc_go && !tag_hit;
  assign clr_bits = alloc || inv_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (inv_hit) begin
      valid_q <= 1'b0;
    end else if (alloc) begin
      valid_q <= 1'b1;
      tag_q   <= acc_epoch;
    end
  end

  AST_INV_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_hit |=> !valid_q); // R7

  AST_ACCESS_OWNS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> (valid_q && tag_q == $past(acc_epoch))); // R8

endmodule

// File: rtl/spec_word_cell.sv
module spec_word_cell
  import spec_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel,
  input  logic is_wr,
  output logic wr_q,
  output logic xr_q
);
  logic base_w, base_x;

  assign base_w = clr ? 1'b0 : wr_q;
  assign base_x = clr ? 1'b0 : xr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      xr_q <= 1'b0;
    end else begin
      wr_q <= base_w || (sel && is_wr);
      xr_q <= xr_next(base_x, base_w, sel, !is_wr);
    end
  end

  AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && is_wr) |=> wr_q); // R1

  AST_READ_AFTER_WRITE_KEEPS_XR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !is_wr && !clr && wr_q) |=> (xr_q == $past(xr_q))); // R3

endmodule

// File: rtl/spec_snoop_chk.sv
module spec_snoop_chk
  import spec_trk_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int WIDX = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_ok,
  input  logic             snp_valid,
  input  logic [WIDX-1:0]  snp_word,
  input  logic [1:0]       snp_rel,
  input  logic [WORDS-1:0] xr_vec,
  output logic             viol
);
  ord_rel_e rel;

  assign rel  = ord_rel_e'(snp_rel);
  assign viol = snp_valid && line_ok && is_violation(rel, xr_vec[snp_word]);

  AST_NO_VIOL_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !line_ok |-> !viol); // R6

  AST_VIOL_NEEDS_OLDER_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (snp_rel == 2'b01)); // R5

endmodule

// File: rtl/spec_word_tracker.sv
module spec_word_tracker
  import spec_trk_pkg::*;
#(
  parameter int WORDS   = 8,
  parameter int EPOCH_W = 6,
  localparam int WIDX   = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [WIDX-1:0]    acc_word,
  input  logic [EPOCH_W-1:0] acc_epoch,
  input  logic               inv_valid,
  input  logic [EPOCH_W-1:0] inv_epoch,
  input  logic               snp_valid,
  input  logic [WIDX-1:0]    snp_word,
  input  logic [1:0]         snp_rel,
  output logic               rd_exposed,
  output logic               dep_viol,
  output logic               line_valid,
  output logic [EPOCH_W-1:0] line_epoch
);
  logic             tag_hit, inv_hit, acc_go, clr_bits;
  logic [WORDS-1:0] wr_vec, xr_vec;

  spec_line_tag #(.EPOCH_W(EPOCH_W)) tag_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_epoch(acc_epoch),
    .inv_valid(inv_valid), .inv_epoch(inv_epoch),
    .valid_q(line_valid), .tag_q(line_epoch),
    .tag_hit(tag_hit), .inv_hit(inv_hit),
    .acc_go(acc_go), .clr_bits(clr_bits)
  );

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic sel;
    assign sel = acc_go && (acc_word == WIDX'(gi));
    spec_word_cell cell_i (
      .clk(clk), .rst_n(rst_n),
      .clr(clr_bits), .sel(sel), .is_wr(acc_write),
      .wr_q(wr_vec[gi]), .xr_q(xr_vec[gi])
    );
  end

  assign rd_exposed = acc_valid && !acc_write &&
                      (!tag_hit || word_needs_fill(wr_vec[acc_word], xr_vec[acc_word]));

  spec_snoop_chk #(.WORDS(WORDS)) snp_i (
    .clk(clk), .rst_n(rst_n), .line_ok(line_valid),
    .snp_valid(snp_valid), .snp_word(snp_word), .snp_rel(snp_rel),
    .xr_vec(xr_vec), .viol(dep_viol)
  );

  AST_FOREIGN_READ_EXPOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !(line_valid && line_epoch == acc_epoch)) |-> rd_exposed); // R4

  AST_EXPOSED_READ_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_exposed && !inv_hit) |=> xr_vec[$past(acc_word)]); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !snp_valid) |-> (!rd_exposed && !dep_viol)); // R9

endmodule

// File: tb/spec_word_tracker_tb.sv
module spec_word_tracker_tb_top;
  localparam int WORDS = 8;
  localparam int EW    = 6;
  localparam int WIDX  = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0;
  logic [WIDX-1:0] acc_word = '0;
  logic [EW-1:0] acc_epoch = '0;
  logic inv_valid = 0;
  logic [EW-1:0] inv_epoch = '0;
  logic snp_valid = 0;
  logic [WIDX-1:0] snp_word = '0;
  logic [1:0] snp_rel = 2'b00;
  logic rd_exposed, dep_viol, line_valid;
  logic [EW-1:0] line_epoch;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spec_word_tracker #(.WORDS(WORDS), .EPOCH_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_word(acc_word), .acc_epoch(acc_epoch),
    .inv_valid(inv_valid), .inv_epoch(inv_epoch),
    .snp_valid(snp_valid), .snp_word(snp_word), .snp_rel(snp_rel),
    .rd_exposed(rd_exposed), .dep_viol(dep_viol),
    .line_valid(line_valid), .line_epoch(line_epoch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // local access; exposure checked before the edge
  task automatic access(input logic wr, input int w, input int ep,
                        input logic exp_x, input string req);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_word = WIDX'(w); acc_epoch = EW'(ep);
    #2 chk(req, rd_exposed, exp_x);
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic snoop(input int w, input logic [1:0] rel, input logic exp_v, input string req);
    @(negedge clk);
    snp_valid = 1; snp_word = WIDX'(w); snp_rel = rel;
    #2 chk(req, dep_viol, exp_v);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic squash(input int ep);
    @(negedge clk);
    inv_valid = 1; inv_epoch = EW'(ep);
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic t_reset();
    #2;
    chk("R9 valid after reset", line_valid, 0);
    chk("R9 exposed idle", rd_exposed, 0);
    chk("R9 viol idle", dep_viol, 0);
  endtask

  task automatic t_first_read();
    access(0, 2, 5, 1, "R4 read on empty slot");
    chk("R8 valid after alloc", line_valid, 1);
    chk("R8 tag after alloc", line_epoch, 5);
    access(0, 2, 5, 0, "R3 repeat read local");
  endtask

  task automatic t_word_flags();
    access(1, 3, 5, 0, "R1 write not exposed");
    access(0, 3, 5, 0, "R1 read of written word local");
    access(0, 4, 5, 1, "R2 read of untouched word exposed");
    snoop(2, 2'b01, 1, "R5 older writer on read word");
    snoop(4, 2'b01, 1, "R2 exposed flag set by read");
    snoop(3, 2'b01, 0, "R5 written-only word");
    snoop(5, 2'b01, 0, "R5 untouched neighbour");
  endtask

  task automatic t_relations();
    snoop(2, 2'b00, 0, "R6 same epoch");
    snoop(2, 2'b10, 0, "R6 younger writer");
    snoop(2, 2'b11, 0, "R6 unordered");
  endtask

  task automatic t_read_after_write();
    access(1, 6, 5, 0, "R3 write w6");
    access(0, 6, 5, 0, "R3 read after write local");
    snoop(6, 2'b01, 0, "R3 no exposed flag after read-after-write");
  endtask

  task automatic t_squash();
    squash(9);
    chk("R7 foreign squash ignored", line_valid, 1);
    snoop(2, 2'b01, 1, "R7 flags kept after foreign squash");
    squash(5);
    chk("R7 matching squash drops", line_valid, 0);
    snoop(2, 2'b01, 0, "R6 no viol on empty slot");
  endtask

  task automatic t_new_copy();
    access(1, 1, 7, 0, "R8 write allocates");
    chk("R8 tag 7", line_epoch, 7);
    access(0, 2, 7, 1, "R8 fresh flags on w2");
    access(0, 1, 8, 1, "R4 foreign epoch read");
    chk("R8 tag 8", line_epoch, 8);
    snoop(1, 2'b01, 1, "R8 read gives exposed flag in new copy");
    snoop(2, 2'b01, 0, "R8 old flags cleared");
    access(0, 1, 8, 0, "R3 owner re-read local");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_first_read();
    t_word_flags();
    t_relations();
    t_read_after_write();
    t_squash();
    t_new_copy();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule